// File: doc/BRIEF.md
# Latched PHY Status Register

This block is the read-only 16-bit status word of a 10/100 Ethernet PHY management map. It samples level indications from the PHY datapath and from auto-negotiation (link, speed, duplex, jabber, loopback, crossover state) and holds event indications until software acknowledges them. The acknowledgement differs from bit to bit. Most sticky bits are released by reading some *other* register in the management map, such as the counter or the interrupt register that owns the event. The two datapath lock indications work the other way. They latch low, and only a read of this status word itself re-arms them.

The block watches every management access: a strobe, a 5-bit register address and a write flag. It treats only reads as acknowledgements. The read data is a registered view of the state, so a read returns the word as it stood before any clear that the read itself triggers.

Top module: `phy_status_reg`

## Requirements
- R1: Bit 13 (receive-error latch) becomes 1 in the cycle after an `ev_rx_err` pulse and returns to 0 only after a read access to address 0x15.
- R2: Bit 11 (false-carrier latch) becomes 1 after an `ev_false_carrier` pulse and is cleared only by a read access to address 0x14.
- R3: Bit 12 (inverted polarity) becomes 1 after an `ev_pol_inv` pulse and is cleared only by a read access to address 0x1A. A read of this register's own address (`SELF_ADDR`, default 0x11) leaves it set.
- R4: Bit 8 (link-code page received) becomes 1 after an `ev_page_rx` pulse and is cleared only by a read access to address 0x06.
- R5: Bit 7 (interrupt pending) becomes 1 after an `ev_irq` pulse and is cleared only by a read access to address 0x12.
- R6: Bit 6 (remote fault) becomes 1 after an `ev_remote_fault` pulse and is cleared by a read access to address 0x01 or by reset.
- R7: Bits 10 (signal detect) and 9 (descrambler lock) latch low. When the live input is 0, the bit reads 0 from the next cycle and stays 0 until a read of `SELF_ADDR`. From the cycle after that read, the bit follows the live input again. Out of reset, both bits read 0 until the first such read.
- R8: One cycle after they are sampled, these bits mirror their live inputs: 14 (MDI-X swapped), 5 (jabber), 4 (auto-negotiation complete), 3 (loopback active), 2 (duplex, 1 = full), 1 (speed, 0 = 100 Mb/s, 1 = 10 Mb/s) and 0 (link up). Bit 15 always reads 0.
- R9: While reset is held, the read data is 0x0002: speed reads 1 and every other bit reads 0.
- R10: When a sticky bit's set pulse arrives in the same cycle as its clearing read, the bit stays or becomes 1.
- R11: A write access (`acc_write` = 1) to any clearing address or to `SELF_ADDR` clears no latch.
- R12: During the cycle of a clearing read, `rd_data` still shows the value held before that clear. The clear is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_stb | input | 1 | Management access strobe, one cycle per access |
| acc_addr | input | 5 | Register address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| ev_rx_err | input | 1 | Receive-error event pulse |
| ev_false_carrier | input | 1 | False-carrier event pulse |
| ev_pol_inv | input | 1 | Inverted-polarity detection pulse |
| ev_page_rx | input | 1 | New link-code page pulse |
| ev_irq | input | 1 | Internal interrupt pulse |
| ev_remote_fault | input | 1 | Link-partner remote-fault notification pulse |
| sig_det | input | 1 | Live 100BASE-TX signal detect |
| dscr_lock | input | 1 | Live descrambler lock |
| mdix_swapped | input | 1 | Live crossover state, 1 = pairs swapped |
| jabber | input | 1 | Live jabber condition |
| an_done | input | 1 | Live auto-negotiation complete |
| loopback | input | 1 | Live loopback active |
| full_duplex | input | 1 | Live duplex, 1 = full |
| speed_10 | input | 1 | Live speed, 1 = 10 Mb/s, 0 = 100 Mb/s |
| link_up | input | 1 | Live link status |
| rd_data | output | 16 | Status word |

## Verification
Assertions check the per-cycle rules of each latch on every clock: a set pulse always wins, a held bit stays held unless its own clear arrives, a clear with no set drops the bit, a low live input pulls a latched-low bit down, and a write access never releases the receive-error latch. Other behaviours need a scenario to show them. Each sticky bit ignores every clearing address but its own, and a self-read leaves the polarity bit alone. Read data in the clearing cycle still shows the old value. Reset leaves 0x0002, and the latched-low bits stay at 0 after the input recovers until they are re-armed. The bench's behavioural model, compared every cycle across a long random mix of accesses and events, covers these.

// File: rtl/phy_stat_pkg.sv
// Package: shared widths, bit positions and the clear-address map of the
// latched PHY status word. Assumes a 5-bit management address space.
package phy_stat_pkg;

    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int N_STICKY = 6;
    localparam int N_LIVE   = 7;
    localparam int N_LLOW   = 2;

    // Reset image of the live-sampled bits (index order of live_pos): speed = 1
    localparam logic [N_LIVE-1:0] LIVE_RST = 7'b0000010;

    // Bit position of each sticky latch inside the status word
    function automatic int sticky_pos(input int idx);
        case (idx)
            0:       return 13;  // receive error
            1:       return 11;  // false carrier
            2:       return 12;  // inverted polarity
            3:       return 8;   // page received
            4:       return 7;   // interrupt pending
            default: return 6;   // remote fault
        endcase
    endfunction

    // Address whose read access releases each sticky latch
    function automatic logic [ADDR_W-1:0] sticky_clr_addr(input int idx);
        case (idx)
            0:       return 5'h15;
            1:       return 5'h14;
            2:       return 5'h1A;
            3:       return 5'h06;
            4:       return 5'h12;
            default: return 5'h01;
        endcase
    endfunction

    // Bit position of each live-sampled bit
    function automatic int live_pos(input int idx);
        case (idx)
            0:       return 0;   // link
            1:       return 1;   // speed
            2:       return 2;   // duplex
            3:       return 3;   // loopback
            4:       return 4;   // auto-negotiation done
            5:       return 5;   // jabber
            default: return 14;  // crossover swapped
        endcase
    endfunction

    // Bit position of each latched-low bit
    function automatic int llow_pos(input int idx);
        return (idx == 0) ? 10 : 9;  // signal detect, descrambler lock
    endfunction

endpackage

// File: rtl/stat_sticky_bit.sv
// Sticky event latch: sets on a pulse and holds until its clear arrives.
// Assumes set and clear are single-cycle qualified strobes; set wins a tie.
module stat_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Latch update: set has priority over clear, reset drops the bit
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);

    // R1
    held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !set_i && !clr_i) |=> q_o);

    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/stat_latch_low.sv
// Latched-low indication: a low live input pulls the bit to 0, where it
// stays until a re-arm strobe; afterwards the bit tracks the live input.
// Assumes the re-arm strobe is one cycle wide. Reset leaves the bit low.
module stat_latch_low (
    input  logic clk,
    input  logic rst_n,
    input  logic live_i,
    input  logic rearm_i,
    output logic q_o
);

    // Drop on low input; rise only if already high or being re-armed
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= live_i & (q_o | rearm_i);
    end

    // R7
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live_i |=> !q_o);

    // R7
    stay_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_o && !rearm_i) |=> !q_o);

endmodule

// File: rtl/stat_live_sample.sv
// Registers a vector of level indications once per cycle.
// Assumes inputs are already synchronous to clk. RST_VAL is the reset image.
module stat_live_sample #(
    parameter int            W       = 7,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Sample the live levels, loading the reset image under reset
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= RST_VAL;
        else        q_o <= d_i;
    end

endmodule

// File: rtl/phy_status_reg.sv
// Latched PHY status word. Combines live-sampled levels, sticky event latches
// released by reads of other addresses, and latched-low lock indications
// re-armed by reads of this word. Assumes one access per acc_stb cycle; only
// read accesses act as acknowledgements.
module phy_status_reg
    import phy_stat_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SELF_ADDR = 5'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              ev_rx_err,
    input  logic              ev_false_carrier,
    input  logic              ev_pol_inv,
    input  logic              ev_page_rx,
    input  logic              ev_irq,
    input  logic              ev_remote_fault,
    input  logic              sig_det,
    input  logic              dscr_lock,
    input  logic              mdix_swapped,
    input  logic              jabber,
    input  logic              an_done,
    input  logic              loopback,
    input  logic              full_duplex,
    input  logic              speed_10,
    input  logic              link_up,
    output logic [DATA_W-1:0] rd_data
);

    logic                rd_ack;
    logic [N_STICKY-1:0] ev_vec, clr_vec, sticky_q;
    logic [N_LIVE-1:0]   live_vec, live_q;
    logic [N_LLOW-1:0]   llow_in, llow_q;

    // Only reads acknowledge events
    assign rd_ack   = acc_stb & ~acc_write;
    assign ev_vec   = {ev_remote_fault, ev_irq, ev_page_rx,
                       ev_pol_inv, ev_false_carrier, ev_rx_err};
    assign live_vec = {mdix_swapped, jabber, an_done, loopback,
                       full_duplex, speed_10, link_up};
    assign llow_in  = {dscr_lock, sig_det};

    // One sticky latch per event, each released by its own address
    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        assign clr_vec[i] = rd_ack && (acc_addr == sticky_clr_addr(i));
        stat_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (ev_vec[i]),
            .clr_i (clr_vec[i]),
            .q_o   (sticky_q[i])
        );
    end

    // Latched-low bits re-armed by a read of this word
    for (genvar j = 0; j < N_LLOW; j++) begin : g_llow
        stat_latch_low u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .live_i  (llow_in[j]),
            .rearm_i (rd_ack && (acc_addr == SELF_ADDR)),
            .q_o     (llow_q[j])
        );
    end

    stat_live_sample #(
        .W       (N_LIVE),
        .RST_VAL (LIVE_RST)
    ) u_live (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (live_vec),
        .q_o   (live_q)
    );

    // Place every stored bit at its position; bit 15 stays 0
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_LIVE; k++)   rd_data[live_pos(k)]   = live_q[k];
        for (int k = 0; k < N_STICKY; k++) rd_data[sticky_pos(k)] = sticky_q[k];
        for (int k = 0; k < N_LLOW; k++)   rd_data[llow_pos(k)]   = llow_q[k];
    end

    // R11
    write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_stb && acc_write && rd_data[13]) |=> rd_data[13]);

    // R8
    link_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> rd_data[0]);

    // R8
    link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> !rd_data[0]);

    // R8
    top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15]);

endmodule

// File: tb/phy_status_reg_tb.sv
// Bench: behavioural model updated on every rising edge, compared with the
// design on every falling edge, plus directed scenarios per requirement.
module phy_status_reg_tb;

    localparam int CLK_P = 10;
    localparam logic [4:0] SELF = 5'h11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_stb = 1'b0, acc_write = 1'b0;
    logic [4:0] acc_addr = '0;
    logic ev_rx_err = 0, ev_false_carrier = 0, ev_pol_inv = 0;
    logic ev_page_rx = 0, ev_irq = 0, ev_remote_fault = 0;
    logic sig_det = 0, dscr_lock = 0, mdix_swapped = 0, jabber = 0;
    logic an_done = 0, loopback = 0, full_duplex = 0, speed_10 = 0, link_up = 0;
    logic [15:0] rd_data;

    integer checks = 0;
    integer errors = 0;
    bit     armed = 0;
    bit     done = 0;
    logic [15:0] model = 'x;

    always #(CLK_P/2) clk = ~clk;

    phy_status_reg #(.SELF_ADDR(SELF)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_addr(acc_addr),
        .acc_write(acc_write), .ev_rx_err(ev_rx_err),
        .ev_false_carrier(ev_false_carrier), .ev_pol_inv(ev_pol_inv),
        .ev_page_rx(ev_page_rx), .ev_irq(ev_irq),
        .ev_remote_fault(ev_remote_fault), .sig_det(sig_det),
        .dscr_lock(dscr_lock), .mdix_swapped(mdix_swapped), .jabber(jabber),
        .an_done(an_done), .loopback(loopback), .full_duplex(full_duplex),
        .speed_10(speed_10), .link_up(link_up), .rd_data(rd_data)
    );

    function automatic bit reads(input logic [4:0] a);
        return acc_stb && !acc_write && (acc_addr == a);
    endfunction

    function automatic string req_of(input int b);
        case (b)
            13: return "R1";   11: return "R2";  12: return "R3";
            8:  return "R4";   7:  return "R5";  6:  return "R6";
            10, 9: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference model: next state of the status word from the requirements
    always @(posedge clk) begin
        logic [15:0] nx;
        if (!rst_n) model <= 16'h0002;
        else begin
            nx = 16'h0000;
            nx[14] = mdix_swapped; nx[5] = jabber;      nx[4] = an_done;
            nx[3]  = loopback;     nx[2] = full_duplex; nx[1] = speed_10;
            nx[0]  = link_up;
            nx[13] = ev_rx_err        | (model[13] & ~reads(5'h15));
            nx[11] = ev_false_carrier | (model[11] & ~reads(5'h14));
            nx[12] = ev_pol_inv       | (model[12] & ~reads(5'h1A));
            nx[8]  = ev_page_rx       | (model[8]  & ~reads(5'h06));
            nx[7]  = ev_irq           | (model[7]  & ~reads(5'h12));
            nx[6]  = ev_remote_fault  | (model[6]  & ~reads(5'h01));
            nx[10] = sig_det   & (model[10] | reads(SELF));
            nx[9]  = dscr_lock & (model[9]  | reads(SELF));
            model <= nx;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !$isunknown(model)) begin
            checks++;
            if (rd_data !== model) begin
                errors++;
                for (int b = 0; b < 16; b++)
                    if (rd_data[b] !== model[b])
                        $display("FAIL %s model bit %0d: actual=%b expected=%b",
                                 req_of(b), b, rd_data[b], model[b]);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        acc_stb = 0; acc_write = 0;
        ev_rx_err = 0; ev_false_carrier = 0; ev_pol_inv = 0;
        ev_page_rx = 0; ev_irq = 0; ev_remote_fault = 0;
    endtask

    task automatic access(input logic [4:0] a, input bit wr);
        acc_stb = 1; acc_addr = a; acc_write = wr;
        step();
        quiet();
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        armed = 1;
        sig_det = 1; dscr_lock = 1; link_up = 1; speed_10 = 0;
        step(); step(); step();
        chk("R9 reset image", rd_data, 16'h0002);
        rst_n = 1;
        // R8: live pattern
        mdix_swapped = 1; jabber = 1; an_done = 1; loopback = 1;
        full_duplex = 1; speed_10 = 0; link_up = 1;
        step();
        chk("R8 live bits", rd_data & 16'hC03F, 16'h403D);
        speed_10 = 1; full_duplex = 0; mdix_swapped = 0;
        step();
        chk("R8 live bits second", rd_data & 16'hC03F, 16'h003B);
        // R1 and R12
        ev_rx_err = 1; step(); ev_rx_err = 0;
        chk("R1 set", rd_data[13], 1);
        access(5'h14, 0);
        chk("R1 other address", rd_data[13], 1);
        acc_stb = 1; acc_addr = 5'h15; acc_write = 0;
        chk("R12 pre-clear view", rd_data[13], 1);
        step(); quiet();
        chk("R1 cleared", rd_data[13], 0);
        // R2 and R11
        ev_false_carrier = 1; step(); ev_false_carrier = 0;
        access(5'h14, 1);
        chk("R11 write ignored", rd_data[11], 1);
        access(SELF, 1);
        chk("R11 self write ignored", rd_data[11], 1);
        access(5'h14, 0);
        chk("R2 cleared", rd_data[11], 0);
        // R3
        ev_pol_inv = 1; step(); ev_pol_inv = 0;
        access(SELF, 0);
        chk("R3 self read keeps", rd_data[12], 1);
        access(5'h1A, 0);
        chk("R3 cleared", rd_data[12], 0);
        // R4 and R10
        ev_page_rx = 1; step(); ev_page_rx = 0;
        chk("R4 set", rd_data[8], 1);
        ev_page_rx = 1; access(5'h06, 0);
        chk("R10 set wins", rd_data[8], 1);
        access(5'h06, 0);
        chk("R4 cleared", rd_data[8], 0);
        // R5
        ev_irq = 1; step(); ev_irq = 0;
        chk("R5 set", rd_data[7], 1);
        access(5'h01, 0);
        chk("R5 other address", rd_data[7], 1);
        access(5'h12, 0);
        chk("R5 cleared", rd_data[7], 0);
        // R6
        ev_remote_fault = 1; step(); ev_remote_fault = 0;
        chk("R6 set", rd_data[6], 1);
        access(5'h01, 0);
        chk("R6 cleared by read", rd_data[6], 0);
        ev_remote_fault = 1; step(); ev_remote_fault = 0;
        rst_n = 0; step();
        chk("R6 cleared by reset", rd_data[6], 0);
        rst_n = 1; step();
        // R7
        chk("R7 low until re-armed", rd_data[10:9], 2'b00);
        access(SELF, 0);
        chk("R7 follows after read", rd_data[10:9], 2'b11);
        sig_det = 0; step(); sig_det = 1;
        chk("R7 drop", rd_data[10:9], 2'b01);
        step(); step();
        chk("R7 held low", rd_data[10:9], 2'b01);
        acc_stb = 1; acc_addr = SELF; acc_write = 0;
        chk("R12 latched-low pre-rearm", rd_data[10], 0);
        step(); quiet();
        chk("R7 re-armed", rd_data[10:9], 2'b11);
        // Random mix compared against the model
        for (int n = 0; n < 4000; n++) begin
            int pick;
            ev_rx_err        = ($urandom_range(0, 9) == 0);
            ev_false_carrier = ($urandom_range(0, 9) == 0);
            ev_pol_inv       = ($urandom_range(0, 9) == 0);
            ev_page_rx       = ($urandom_range(0, 9) == 0);
            ev_irq           = ($urandom_range(0, 9) == 0);
            ev_remote_fault  = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 7) == 0) sig_det   = ~sig_det;
            if ($urandom_range(0, 7) == 0) dscr_lock = ~dscr_lock;
            {mdix_swapped, jabber, an_done, loopback} = 4'($urandom);
            {full_duplex, speed_10, link_up} = 3'($urandom);
            acc_stb   = ($urandom_range(0, 2) == 0);
            acc_write = ($urandom_range(0, 3) == 0);
            pick = $urandom_range(0, 7);
            case (pick)
                0: acc_addr = 5'h15;  1: acc_addr = 5'h14;
                2: acc_addr = 5'h1A;  3: acc_addr = 5'h06;
                4: acc_addr = 5'h12;  5: acc_addr = 5'h01;
                6: acc_addr = SELF;
                default: acc_addr = 5'($urandom);
            endcase
            rst_n = ($urandom_range(0, 499) != 0);
            step();
        end
        rst_n = 1; quiet();
        step(); step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule